// File: doc/BRIEF.md
# Four-plane display write datapath

This block turns one processor write byte into the four bytes that a four-plane display memory stores at one address. It receives the processor byte, the four latched bytes that the previous read of that address left, and a set of configuration fields. From these it produces one byte per plane and a write strobe for each plane. The configuration fields are a write mode, a rotate count, a logical function, a per-plane fill colour, a per-plane fill enable, a pixel mask and a plane enable.

Four write modes are supported. Mode 0 rotates the processor byte and can replace it with a fill colour per plane. Mode 1 copies the latches unchanged, so that data can be moved from one memory location to another. Mode 2 spreads one data bit across each plane. Mode 3 paints the fill colour through a pattern that comes from the rotated byte and the mask. A write is offered with `wr_valid`. The result appears on the outputs through one register stage and stays there until the next write.

Top module: `planar_write_path`

## Requirements
- R1: While reset is asserted, and on the first sampled cycle after it, `plane_data` is all zeros and `plane_we` is 4'b0000.
- R2: One clock after a cycle with `wr_valid`=1, `plane_we` equals the `plane_en` of that cycle. One clock after a cycle with `wr_valid`=0, `plane_we` is 4'b0000.
- R3: In `wr_mode`=0, a plane without fill enable uses the processor byte rotated right by `rot_cnt` positions (bit i moves to bit i-`rot_cnt` modulo 8).
- R4: In `wr_mode`=0, a plane p with `sr_enable[p]`=1 uses 8 copies of `sr_color[p]` in place of the rotated byte. Plane p occupies bits [8p+7:8p] of `latch_bus` and `plane_data`.
- R5: In `wr_mode` 0 and 2, `logic_op` merges the source with the plane latch: 0 passes the source, 1 ANDs it with the latch, 2 ORs it with the latch, 3 XORs it with the latch.
- R6: In `wr_mode`=1, every plane receives its latch byte. The processor byte, mask, logical function and fill fields have no effect.
- R7: In `wr_mode`=2, plane p uses 8 copies of `cpu_data[p]` as its source.
- R8: In all modes, a pixel whose `bit_mask` bit is 0 keeps the latched bit of every plane.
- R9: In `wr_mode`=3, the rotated processor byte ANDed with `bit_mask` selects pixels. Each selected pixel of plane p takes `sr_color[p]`, and each other pixel keeps the latch.
- R10: While `wr_valid` is 0, `plane_data` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | A write is offered in this cycle |
| cpu_data | input | 8 | Processor write byte |
| latch_bus | input | 32 | Latched bytes, plane p at bits [8p+7:8p] |
| wr_mode | input | 2 | Write mode, 0 to 3 |
| rot_cnt | input | 3 | Right-rotate count |
| logic_op | input | 2 | 0 pass, 1 AND, 2 OR, 3 XOR |
| sr_color | input | 4 | Fill colour, one bit per plane |
| sr_enable | input | 4 | Fill enable for mode 0, one bit per plane |
| bit_mask | input | 8 | Pixel update mask |
| plane_en | input | 4 | Plane write enable |
| plane_data | output | 32 | Plane bytes, plane p at bits [8p+7:8p] |
| plane_we | output | 4 | Per-plane write strobes |

## Verification
Every result of a write, both the plane bytes and the strobes, is due exactly one rising edge after the cycle in which `wr_valid` was high. No other path reaches the outputs. The bench changes its inputs on a falling edge and samples on the next falling edge, which is one edge after the register has loaded. The hold and idle checks drive new, different inputs with `wr_valid` low and sample one edge later. Both outputs are checked to have kept or cleared their values.

// File: rtl/planar_write_path.sv
module planar_write_path #(
  parameter int PLANES = 4,
  parameter int PIX    = 8,
  localparam int RW    = $clog2(PIX),
  localparam int BUS   = PLANES * PIX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [PIX-1:0]    cpu_data,
  input  logic [BUS-1:0]    latch_bus,
  input  logic [1:0]        wr_mode,
  input  logic [RW-1:0]     rot_cnt,
  input  logic [1:0]        logic_op,
  input  logic [PLANES-1:0] sr_color,
  input  logic [PLANES-1:0] sr_enable,
  input  logic [PIX-1:0]    bit_mask,
  input  logic [PLANES-1:0] plane_en,
  output logic [BUS-1:0]    plane_data,
  output logic [PLANES-1:0] plane_we
);

  localparam logic [1:0] MODE_ALU  = 2'd0;
  localparam logic [1:0] MODE_COPY = 2'd1;
  localparam logic [1:0] MODE_SPRD = 2'd2;
  localparam logic [1:0] MODE_PAT  = 2'd3;

  logic [2*PIX-1:0] dbl;
  logic [PIX-1:0]   rotated;
  logic [PIX-1:0]   pattern;
  logic [BUS-1:0]   next_bus;

  assign dbl     = {cpu_data, cpu_data} >> rot_cnt;
  assign rotated = dbl[PIX-1:0];
  assign pattern = rotated & bit_mask;

  for (genvar p = 0; p < PLANES; p++) begin : g_plane
    logic [PIX-1:0] lat, fill, src, alu, res;

    assign lat  = latch_bus[p*PIX +: PIX];
    assign fill = {PIX{sr_color[p]}};

    always_comb begin
      if (wr_mode == MODE_SPRD)
        src = {PIX{cpu_data[p]}};
      else if (sr_enable[p])
        src = fill;
      else
        src = rotated;
    end

    always_comb begin
      case (logic_op)
        2'd1:    alu = src & lat;
        2'd2:    alu = src | lat;
        2'd3:    alu = src ^ lat;
        default: alu = src;
      endcase
    end

    always_comb begin
      case (wr_mode)
        MODE_COPY: res = lat;
        MODE_PAT:  res = (pattern & fill) | (~pattern & lat);
        MODE_ALU,
        MODE_SPRD: res = (alu & bit_mask) | (~bit_mask & lat);
        default:   res = lat;
      endcase
    end

    assign next_bus[p*PIX +: PIX] = res;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      plane_data <= '0;
      plane_we   <= '0;
    end else begin
      plane_we <= wr_valid ? plane_en : '0;
      if (wr_valid)
        plane_data <= next_bus;
    end
  end

endmodule

// File: rtl/planar_write_path_chk.sv
module planar_write_path_chk #(
  parameter int PLANES = 4,
  parameter int PIX    = 8,
  localparam int RW    = $clog2(PIX),
  localparam int BUS   = PLANES * PIX
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic [PIX-1:0]    cpu_data,
  input logic [BUS-1:0]    latch_bus,
  input logic [1:0]        wr_mode,
  input logic [RW-1:0]     rot_cnt,
  input logic [1:0]        logic_op,
  input logic [PLANES-1:0] sr_color,
  input logic [PLANES-1:0] sr_enable,
  input logic [PIX-1:0]    bit_mask,
  input logic [PLANES-1:0] plane_en,
  input logic [BUS-1:0]    plane_data,
  input logic [PLANES-1:0] plane_we
);

  assert_we_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> plane_we == $past(plane_en));

  assert_we_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> plane_we == '0);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> $stable(plane_data));

  assert_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_mode == 2'd1) |=> plane_data == $past(latch_bus));

  assert_mask_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> ((plane_data ^ $past(latch_bus)) & ~{PLANES{$past(bit_mask)}}) == '0);

  for (genvar p = 0; p < PLANES; p++) begin : g_chk
    assert_spread_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_mode == 2'd2 && logic_op == 2'd0 && bit_mask == '1)
      |=> plane_data[p*PIX +: PIX] == {PIX{$past(cpu_data[p])}});

    assert_paint_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_mode == 2'd3 && bit_mask == '1 && cpu_data == '1)
      |=> plane_data[p*PIX +: PIX] == {PIX{$past(sr_color[p])}});
  end

endmodule

bind planar_write_path planar_write_path_chk #(.PLANES(PLANES), .PIX(PIX)) u_chk (.*);

// File: tb/tb_planar_write_path.sv
module tb_planar_write_path;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_valid;
  logic [7:0]  cpu_data;
  logic [31:0] latch_bus;
  logic [1:0]  wr_mode;
  logic [2:0]  rot_cnt;
  logic [1:0]  logic_op;
  logic [3:0]  sr_color, sr_enable, plane_en;
  logic [7:0]  bit_mask;
  logic [31:0] plane_data;
  logic [3:0]  plane_we;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  planar_write_path dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .cpu_data(cpu_data),
    .latch_bus(latch_bus), .wr_mode(wr_mode), .rot_cnt(rot_cnt),
    .logic_op(logic_op), .sr_color(sr_color), .sr_enable(sr_enable),
    .bit_mask(bit_mask), .plane_en(plane_en), .plane_data(plane_data),
    .plane_we(plane_we)
  );

  localparam logic [31:0] LAT = 32'hF00F_AA55;
  localparam int NV = 16;

  // {mode, rot, op, sr, sre, mask, pen, cpu, expected}
  localparam logic [66:0] TBL [NV] = '{
    {2'd0, 3'd0, 2'd0, 4'h0, 4'h0, 8'hFF, 4'hF, 8'h3C, 32'h3C3C_3C3C}, // R3
    {2'd0, 3'd3, 2'd0, 4'h0, 4'h0, 8'hFF, 4'h1, 8'h81, 32'h3030_3030}, // R3
    {2'd0, 3'd1, 2'd0, 4'h0, 4'h0, 8'hFF, 4'h2, 8'h01, 32'h8080_8080}, // R3
    {2'd0, 3'd0, 2'd0, 4'h1, 4'h5, 8'hFF, 4'h4, 8'h3C, 32'h3C00_3CFF}, // R4
    {2'd0, 3'd0, 2'd1, 4'h0, 4'h0, 8'hFF, 4'h8, 8'h0F, 32'h000F_0A05}, // R5 AND
    {2'd0, 3'd0, 2'd2, 4'h0, 4'h0, 8'hFF, 4'hF, 8'h0F, 32'hFF0F_AF5F}, // R5 OR
    {2'd0, 3'd0, 2'd3, 4'h0, 4'h0, 8'hFF, 4'hF, 8'hFF, 32'h0FF0_55AA}, // R5 XOR
    {2'd0, 3'd0, 2'd0, 4'h0, 4'h0, 8'h0F, 4'hF, 8'h00, 32'hF000_A050}, // R8
    {2'd1, 3'd5, 2'd3, 4'hF, 4'hF, 8'h00, 4'h5, 8'h12, 32'hF00F_AA55}, // R6
    {2'd2, 3'd0, 2'd0, 4'h0, 4'h0, 8'hFF, 4'hF, 8'h05, 32'h00FF_00FF}, // R7
    {2'd2, 3'd0, 2'd3, 4'h0, 4'h0, 8'hFF, 4'hF, 8'h0A, 32'h0F0F_5555}, // R5 in mode 2
    {2'd2, 3'd0, 2'd0, 4'h0, 4'h0, 8'h3C, 4'hF, 8'h0F, 32'hFC3F_BE7D}, // R8
    {2'd3, 3'd0, 2'd0, 4'hA, 4'h0, 8'hFF, 4'hA, 8'hFF, 32'hFF00_FF00}, // R9
    {2'd3, 3'd0, 2'd0, 4'hA, 4'h0, 8'hFF, 4'hF, 8'h0F, 32'hFF00_AF50}, // R9
    {2'd3, 3'd1, 2'd0, 4'hF, 4'h0, 8'hF0, 4'hF, 8'h01, 32'hF08F_AAD5}, // R9 rotated
    {2'd0, 3'd0, 2'd0, 4'h0, 4'hF, 8'hFF, 4'hF, 8'hFF, 32'h0000_0000}  // R4
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(input logic [66:0] v, input logic vld);
    wr_valid  = vld;
    wr_mode   = v[66:65];
    rot_cnt   = v[64:62];
    logic_op  = v[61:60];
    sr_color  = v[59:56];
    sr_enable = v[55:52];
    bit_mask  = v[51:44];
    plane_en  = v[43:40];
    cpu_data  = v[39:32];
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    latch_bus = LAT;
    drive(TBL[0], 1'b1);
    repeat (3) @(negedge clk);
    check("R1 data in reset", plane_data, 32'h0);
    check("R1 we in reset", {28'h0, plane_we}, 32'h0);
    rst_n = 1'b1;
    wr_valid = 1'b0;
    @(negedge clk);
    check("R1 data after reset", plane_data, 32'h0);
    check("R1 we after reset", {28'h0, plane_we}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i], 1'b1);
      @(negedge clk);
      check($sformatf("R3-R9 vector %0d data", i), plane_data, TBL[i][31:0]);
      check($sformatf("R2 vector %0d strobes", i), {28'h0, plane_we}, {28'h0, TBL[i][43:40]});
    end

    drive(TBL[4], 1'b0);
    latch_bus = 32'h1234_5678;
    @(negedge clk);
    check("R10 hold data while idle", plane_data, TBL[NV-1][31:0]);
    check("R2 idle strobes", {28'h0, plane_we}, 32'h0);

    drive(TBL[8], 1'b1);
    @(negedge clk);
    check("R6 copy new latch", plane_data, 32'h1234_5678);
    wr_valid = 1'b0;
    cpu_data = 8'hA5;
    @(negedge clk);
    check("R10 hold after copy", plane_data, 32'h1234_5678);

    latch_bus = LAT;
    drive({2'd0, 3'd7, 2'd0, 4'h0, 4'h0, 8'hFF, 4'h3, 8'h01, 32'h0}, 1'b1);
    @(negedge clk);
    check("R3 rotate by 7", plane_data, 32'h0202_0202);
    check("R2 partial strobes", {28'h0, plane_we}, 32'h3);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule